// File: doc/BRIEF.md
# EEPROM Page-Write Buffer Engine

This block models the page-write logic of a byte-wide parallel EEPROM, running entirely on a system clock. The host drives active-low chip enable, write enable and output enable, an address and a data byte. Each falling edge of write enable, with chip enable low, drops one byte into a temporary page buffer. The upper address bits name a page and the low bits name an offset in it. Bytes may arrive in any order. A repeat load to an offset replaces the earlier value.

Once write enable has stayed high for a set number of clock samples, the block raises `busy` and runs a program cycle. An erase phase first sets every loaded cell to all ones. A program phase then writes the buffered bytes. Only loaded offsets are touched, and every other byte of the page keeps its value. The page number used is the one present at the final load. Reads are combinational: with chip and output enable low and write enable high, `dout` shows the stored byte at `addr`.

The array depth is 2^ADDR_W bytes. The default is kept small for elaboration and can be raised to a 32K-byte device. The timeout and both phase lengths are counted in clock cycles. Each phase must be at least one page long, because a phase visits one offset per cycle.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy` is 0, no bytes are pending, and with `ce_n` high `dout_en` is 0 and `dout` is 0.
- R2: A `we_n` falling edge (previous sample 1, current sample 0) with `ce_n` low and `busy` low stores `din` at offset `addr[PAGE_BITS-1:0]`. Loads may come in any order, and the last load to an offset wins.
- R3: The page programmed is `addr[ADDR_W-1:PAGE_BITS]` at the final load of the sequence. Pages named by earlier loads are left unchanged. The latched page holds steady while busy.
- R4: `busy` rises exactly LOAD_TIMEOUT clock edges after `we_n` is first sampled high following the last load. A load that arrives before then restarts the wait, so the total load window has no limit.
- R5: `busy` stays high for exactly ERASE_CYCLES + PROG_CYCLES cycles.
- R6: During the erase phase every loaded cell reads 8'hFF. Array writes happen only while busy.
- R7: After the cycle, loaded offsets hold their new bytes and unloaded offsets of the page keep their old bytes. The buffer is empty when busy falls.
- R8: Write-enable falling edges while busy are ignored: no byte is stored and no further program cycle follows.
- R9: Write-enable falling edges with `ce_n` high are ignored: no program cycle starts and the array is unchanged.
- R10: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, and then `dout` equals the stored byte at `addr`. Otherwise `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low, sampled each clock |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page in upper bits, offset in low PAGE_BITS |
| din | input | DATA_W | Byte to load |
| dout | output | DATA_W | Read data, zero when not enabled |
| dout_en | output | 1 | Output drive enable |
| busy | output | 1 | Program cycle in progress |

## Verification
On every cycle the assertions check several properties. `busy` never rises before write enable has been high for the full timeout. Each busy period lasts exactly the two phase lengths. The latched page does not move while busy. The buffer is empty when busy drops. The array is written only while busy, and `dout` is zero whenever it is not enabled. Only the bench scenarios can show the rest: that bytes land at the right page and offset, that a repeat load wins, that unloaded neighbours survive, that the erase value appears mid-cycle, and that pulses during busy or with chip enable high leave the array untouched.

// File: rtl/eepw_pkg.sv
// Shared types for the page-write engine.
package eepw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ERASE,
        ST_PROG
    } eepw_state_t;
endpackage

// File: rtl/eepw_we_edge.sv
// Write-enable sampler: registers we_n once per clock and flags a falling edge
// when the previous sample was high and the current one is low.
// Assumes we_n is already synchronous to clk.
module eepw_we_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic we_fall,
    output logic we_high
);
    logic we_q;

    // Hold the previous write-enable sample (idle high out of reset).
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign we_fall = we_q & ~we_n;
    assign we_high = we_n;
endmodule

// File: rtl/eepw_page_buf.sv
// Temporary page buffer: one data register and one valid bit per offset.
// A load writes one entry and sets its valid bit. Clear drops all valid bits.
// Assumes load and clear never coincide (loads are blocked while busy).
module eepw_page_buf #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [PAGE_BITS-1:0] ld_idx,
    input  logic [DATA_W-1:0]    ld_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 any_valid
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [DATA_W-1:0]    data_q [PAGE_SIZE];
    logic [PAGE_SIZE-1:0] valid_q;

    for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_entry
        // Capture the byte for this offset when it is the load target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (load_en && (ld_idx == PAGE_BITS'(g)))
                data_q[g] <= ld_data;
        end

        // Track whether this offset holds a pending byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                valid_q[g] <= 1'b0;
            else if (load_en && (ld_idx == PAGE_BITS'(g)))
                valid_q[g] <= 1'b1;
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign any_valid = |valid_q;
endmodule

// File: rtl/eepw_seq.sv
// Sequencer: accepts loads, latches the page on each load, times the
// byte-load window, then walks every offset once in an erase phase and once
// in a program phase. A loaded offset is written all-ones, then its data.
// Assumes ERASE_CYCLES and PROG_CYCLES are each at least one page long.
module eepw_seq
    import eepw_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_TIMEOUT = 16,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_n,
    input  logic                        we_fall,
    input  logic                        we_high,
    input  logic [ADDR_W-PAGE_BITS-1:0] ld_page,
    input  logic                        buf_valid,
    input  logic [DATA_W-1:0]           buf_data,
    output logic                        load_en,
    output logic [PAGE_BITS-1:0]        buf_idx,
    output logic                        buf_clr,
    output logic                        busy,
    output logic [ADDR_W-PAGE_BITS-1:0] page_lat,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_waddr,
    output logic [DATA_W-1:0]           mem_wdata
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int MAX_AB    = (LOAD_TIMEOUT > ERASE_CYCLES) ? LOAD_TIMEOUT : ERASE_CYCLES;
    localparam int MAX_ABC   = (MAX_AB > PROG_CYCLES) ? MAX_AB : PROG_CYCLES;
    localparam int MAX_CNT   = (MAX_ABC > PAGE_SIZE) ? MAX_ABC : PAGE_SIZE;
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    eepw_state_t      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             in_page;
    logic             walking;

    assign busy    = (state_q == ST_ERASE) || (state_q == ST_PROG);
    assign load_en = we_fall && !ce_n && !busy;

    // Advance the load / erase / program state and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (load_en) state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (load_en || !we_high) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(LOAD_TIMEOUT - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_ERASE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (cnt_q == CNT_W'(ERASE_CYCLES - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_PROG;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Remember the page named by the most recent accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_lat <= '0;
        else if (load_en) page_lat <= ld_page;
    end

    assign buf_idx   = cnt_q[PAGE_BITS-1:0];
    assign in_page   = cnt_q < CNT_W'(PAGE_SIZE);
    assign walking   = busy && in_page;
    assign mem_we    = walking && buf_valid;
    assign mem_waddr = {page_lat, buf_idx};
    assign mem_wdata = (state_q == ST_ERASE) ? '1 : buf_data;
    assign buf_clr   = (state_q == ST_PROG) && (cnt_q == CNT_W'(PROG_CYCLES - 1));
endmodule

// File: rtl/eepw_array.sv
// Storage array: one synchronous write port, one combinational read port.
// Contents are not reset, as in a non-volatile cell array.
module eepw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit one byte per clock when the sequencer requests it.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_page_writer.sv
// Top of the page-write engine. It joins the write-enable sampler, the page
// buffer, the sequencer and the array, and gates read data onto dout.
// Assumes all control inputs are synchronous to clk.
module eeprom_page_writer #(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_TIMEOUT = 16,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic                 we_fall, we_high, load_en, buf_clr;
    logic [PAGE_BITS-1:0] buf_idx;
    logic [DATA_W-1:0]    buf_data, mem_wdata, rdata;
    logic                 buf_valid, buf_any;
    logic [PAGE_W-1:0]    page_lat;
    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;

    eepw_we_edge u_edge (
        .clk(clk), .rst_n(rst_n), .we_n(we_n),
        .we_fall(we_fall), .we_high(we_high)
    );

    eepw_page_buf #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .ld_idx(addr[PAGE_BITS-1:0]), .ld_data(din), .clr(buf_clr),
        .rd_idx(buf_idx), .rd_data(buf_data), .rd_valid(buf_valid),
        .any_valid(buf_any)
    );

    eepw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
        .LOAD_TIMEOUT(LOAD_TIMEOUT), .ERASE_CYCLES(ERASE_CYCLES),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_fall(we_fall),
        .we_high(we_high), .ld_page(addr[ADDR_W-1:PAGE_BITS]),
        .buf_valid(buf_valid), .buf_data(buf_data), .load_en(load_en),
        .buf_idx(buf_idx), .buf_clr(buf_clr), .busy(busy),
        .page_lat(page_lat), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    eepw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr), .rdata(rdata)
    );

    assign dout_en = ~ce_n & ~oe_n & we_n;
    assign dout    = dout_en ? rdata : '0;
endmodule

// File: rtl/eepw_checker.sv
// Cycle-level checks for eeprom_page_writer, attached by bind below.
// Tracks consecutive write-enable-high samples and busy length with counters.
module eepw_checker #(
    parameter int PAGE_W       = 5,
    parameter int DATA_W       = 8,
    parameter int LOAD_TIMEOUT = 16,
    parameter int ERASE_CYCLES = 64,
    parameter int PROG_CYCLES  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_n,
    input logic              busy,
    input logic              dout_en,
    input logic [DATA_W-1:0] dout,
    input logic [PAGE_W-1:0] page_lat,
    input logic              buf_any,
    input logic              mem_we
);
    int hi_cnt;
    int busy_len;

    // Count consecutive high samples of write enable, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !we_n)          hi_cnt <= 0;
        else if (hi_cnt < LOAD_TIMEOUT) hi_cnt <= hi_cnt + 1;
    end

    // Count cycles spent busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= 0;
        else                 busy_len <= busy_len + 1;
    end

    assert_start_after_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> hi_cnt >= LOAD_TIMEOUT);

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == ERASE_CYCLES + PROG_CYCLES);

    assert_page_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_lat));

    assert_buffer_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !buf_any);

    assert_write_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_quiet_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);
endmodule

bind eeprom_page_writer eepw_checker #(
    .PAGE_W(ADDR_W - PAGE_BITS), .DATA_W(DATA_W),
    .LOAD_TIMEOUT(LOAD_TIMEOUT), .ERASE_CYCLES(ERASE_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .busy(busy), .dout_en(dout_en),
    .dout(dout), .page_lat(page_lat), .buf_any(buf_any), .mem_we(mem_we)
);

// File: tb/eeprom_page_writer_test.sv
`timescale 1ns/1ps
module eeprom_page_writer_test;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int PB = 6;
    localparam int T  = 16;
    localparam int E  = 64;
    localparam int P  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, busy;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] exp3 [64];
    logic [DW-1:0] exp7 [64];

    eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB),
        .LOAD_TIMEOUT(T), .ERASE_CYCLES(E), .PROG_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy));

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int page, input int off);
        return AW'(page * 64 + off);
    endfunction

    task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(dout_en && dout == e, req, dout, e);
        oe_n = 1'b1;
    endtask

    // Wait for busy after the last load and check timing, probes and injection.
    task automatic finish(input bit probe, input logic [AW-1:0] pa,
                          input bit inject, input logic [AW-1:0] ia);
        int n = 0;
        int m = 1;
        while (n < 4 * T) begin
            @(negedge clk);
            n++;
            if (busy) break;
        end
        chk(n == T, "R4 busy delay", n, T);
        while (1) begin
            if (probe && m == E + 10) begin
                ce_n = 1'b0; oe_n = 1'b0; addr = pa;
                #1;
                chk(dout == 8'hFF, "R6 erased cell", dout, 8'hFF);
                oe_n = 1'b1;
            end
            if (inject && m == 20) begin
                ce_n = 1'b0; addr = ia; din = 8'h00; we_n = 1'b0;
            end
            if (inject && m == 21) we_n = 1'b1;
            @(negedge clk);
            if (!busy) break;
            m++;
        end
        chk(m == E + P, "R5 busy length", m, E + P);
    endtask

    task automatic quiet_wait(input string req);
        bit seen = 1'b0;
        repeat (T + 10) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        chk(!seen, req, seen, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(dout_en == 1'b0 && dout == '0, "R1 output idle", dout_en, 0);

        // R2/R6: full page 3, loaded in reverse offset order
        for (int o = 63; o >= 0; o--) begin
            exp3[o] = DW'((o * 37 + 11) & 8'hFF);
            do_load(mk(3, o), exp3[o]);
        end
        finish(1'b1, mk(3, 63), 1'b0, '0);
        for (int o = 0; o < 64; o++) rd(mk(3, o), exp3[o], "R2 page 3 readback");

        // R2: full page 7 in ascending order
        for (int o = 0; o < 64; o++) begin
            exp7[o] = DW'(o) ^ 8'h5A;
            do_load(mk(7, o), exp7[o]);
        end
        finish(1'b0, '0, 1'b0, '0);
        for (int o = 0; o < 64; o++) rd(mk(7, o), exp7[o], "R2 page 7 readback");

        // R3/R7/R4: scattered loads naming page 3, last load names page 7
        for (int i = 0; i < 13; i++) begin
            int k = (i * 7) % 13;
            exp7[k * 5] = DW'(8'hA0 + k);
            do_load(mk(3, k * 5), DW'(8'hA0 + k));
            if (i == 6) begin
                repeat (T - 3) @(negedge clk);
                chk(busy == 1'b0, "R4 no start inside window", busy, 0);
            end
        end
        exp7[5] = 8'h3C;
        do_load(mk(7, 5), 8'h3C);
        // R8: pulse during busy aimed at page 3 offset 0
        finish(1'b0, '0, 1'b1, mk(3, 0));
        quiet_wait("R8 no cycle after busy pulse");
        for (int o = 0; o < 64; o++) rd(mk(7, o), exp7[o], "R7 page 7 merge");
        for (int o = 0; o < 64; o++) rd(mk(3, o), exp3[o], "R3 page 3 untouched");

        // R9: write pulse with chip enable high
        @(negedge clk);
        ce_n = 1'b1; addr = mk(7, 1); din = 8'h11; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        quiet_wait("R9 no cycle with ce_n high");
        rd(mk(7, 1), exp7[1], "R9 array unchanged");

        // R10: output enable decode
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = mk(7, 2);
        #1 chk(dout_en == 1'b0 && dout == '0, "R10 oe_n high", dout, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        #1 chk(dout_en == 1'b0 && dout == '0, "R10 ce_n high", dout, 0);
        ce_n = 1'b0; oe_n = 1'b0;
        #1 chk(dout_en == 1'b1 && dout == exp7[2], "R10 read enabled", dout, exp7[2]);
        @(negedge clk);
        we_n = 1'b0; din = exp7[2];
        #1 chk(dout_en == 1'b0 && dout == '0, "R10 we_n low", dout, 0);
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1;
        finish(1'b0, '0, 1'b0, '0);
        rd(mk(7, 2), exp7[2], "R10 rewrite same value");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule